// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host reach the management registers of Ethernet PHYs over the two-wire MDIO interface. The host works through two 32-bit registers on a simple valid-qualified register port. The data register is loaded first. A write to the command register then starts one transaction. Each transaction is either a Clause 22 access or a Clause 45 access, chosen by a bit in the command word.

The block derives MDC from the system clock. A three-bit clock-range code in the command word selects the divider, and the code is latched with each command. Outgoing bits are driven through an output-enable so that a tristate pad can be placed outside the block. The PHY's read data comes back on a separate input. A busy flag in the command register is set by software, is cleared by the block when the last frame ends, and shields both registers while a transaction is running.

Top module: `mdio_master`

## Requirements
- R1: After reset both registers read 0, MDC is low and the output-enable is low.
- R2: Register select 0 is the command register and 1 is the data register. The command fields are:
  - bit 0: busy
  - bit 1: Clause 45 enable
  - bits 3:2: operation (01 write, 11 read)
  - bits 10:8: clock range
  - bits 20:16: register number (Clause 22) or device address (Clause 45)
  - bits 25:21: PHY address

  A command write made while busy reads 1 leaves the whole register unchanged.
- R3: A Clause 22 transaction sends one 64-bit frame, MSB first. The frame is 32 ones, start 01, opcode 01 (write) or 10 (read), PHY address, register number, turnaround 10, then data bits 15:0 of the data register.
- R4: A Clause 45 transaction sends two frames, both with start 00. The first is an address frame with opcode 00 that carries data bits 31:16 as its payload. The second uses opcode 01 (write) or 11 (read) and carries data bits 15:0. Both frames use the PHY and device address fields.
- R5: In a read frame the output-enable is low for the last 18 bit times (turnaround plus data). The 16 bits sampled at the MDC rising edges land in data bits 15:0, and data bits 31:16 are kept.
- R6: The MDC period in system clocks follows the clock-range code: 0→42, 1→62, 2→16, 3→26, 4→102, 5→124, 6 and 7→42. MDC is low whenever busy is 0.
- R7: The outgoing bit changes only on MDC falling edges and is stable while MDC is high.
- R8: Busy clears on exactly the clock edge that is 64×period edges after the edge that accepted the command, or 128×period for Clause 45. A command write that lands on that clearing edge is dropped.
- R9: A data-register write made while busy reads 1 is ignored.
- R10: A command write with busy 0, or with operation 00 or 10, stores its fields with busy reading 0 and starts no MDC activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_valid_i | input | 1 | Register access strobe |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_sel_i | input | 1 | 0 = command register, 1 = data register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Selected register contents |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Outgoing MDIO bit |
| mdio_oe_o | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | Incoming MDIO bit |

## Verification
Two events can fall in the same clock:
- The final MDC falling edge, which clears busy and, for a read, loads the result.
- A host write to one of the two registers.

The bench computes the exact completion edge from the clock-range code and the frame count. It then issues a new command so that its accepting edge coincides with that completion edge. The outcome is judged in two ways: the command register must read back the old fields with busy clear, and MDC must stay idle afterwards. Separately, a data-register write issued mid-read must not disturb either half of the returned data word.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_W = 64;
  localparam int PRE_W   = 32;
  localparam int DATA_W  = 16;
  localparam int FLD_W   = 5;
  localparam int CKSEL_W = 3;
  localparam int HALF_W  = 7;
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam int TA_POS  = FRAME_W - DATA_W - 2;
  localparam int DAT_POS = FRAME_W - DATA_W;

  typedef struct packed {
    logic              c45;
    logic              rd;
    logic [FLD_W-1:0]  phy;
    logic [FLD_W-1:0]  sel;
    logic [31:0]       word;
  } mdio_cmd_t;

  function automatic logic [HALF_W-1:0] half_div(input logic [CKSEL_W-1:0] code);
    case (code)
      3'd1:    half_div = 7'd31;
      3'd2:    half_div = 7'd8;
      3'd3:    half_div = 7'd13;
      3'd4:    half_div = 7'd51;
      3'd5:    half_div = 7'd62;
      default: half_div = 7'd21;
    endcase
  endfunction

  function automatic logic [FRAME_W-1:0] mk_frame(input logic [1:0] st, input logic [1:0] op,
                                                  input logic [FLD_W-1:0] phy,
                                                  input logic [FLD_W-1:0] sel,
                                                  input logic [DATA_W-1:0] d);
    mk_frame = {{PRE_W{1'b1}}, st, op, phy, sel, 2'b10, d};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
  import mdio_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [CKSEL_W-1:0] sel_i,
  output logic               mdc_o,
  output logic               rise_o,
  output logic               fall_o
);
  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] half;
  logic              mdc_q;
  logic              wrap;

  assign half   = half_div(sel_i);
  assign wrap   = en_i && (cnt_q == half - 7'd1);
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 7'd1;
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  mdio_cmd_t         cmd_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdc_i,
  input  logic              mdio_i,
  output logic              active_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  mdio_cmd_t          cmd_q;
  logic               active_q, more_q, rdf_q;
  logic [FRAME_W-1:0] sh_q;
  logic [BIT_W-1:0]   bit_q;
  logic [DATA_W-1:0]  rd_q;
  logic               last_bit;

  assign last_bit  = (bit_q == BIT_W'(FRAME_W - 1));
  assign done_o    = active_q && fall_i && last_bit && !more_q;
  assign active_o  = active_q;
  assign rd_data_o = rd_q;
  assign mdio_o    = sh_q[FRAME_W-1];
  assign mdio_oe_o = active_q && !(rdf_q && bit_q >= BIT_W'(TA_POS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= '0;
      active_q <= 1'b0;
      more_q   <= 1'b0;
      rdf_q    <= 1'b0;
      sh_q     <= '0;
      bit_q    <= '0;
      rd_q     <= '0;
    end else if (start_i && !active_q) begin
      cmd_q    <= cmd_i;
      active_q <= 1'b1;
      bit_q    <= '0;
      if (cmd_i.c45) begin
        sh_q   <= mk_frame(2'b00, 2'b00, cmd_i.phy, cmd_i.sel, cmd_i.word[31:16]);
        rdf_q  <= 1'b0;
        more_q <= 1'b1;
      end else begin
        sh_q   <= mk_frame(2'b01, cmd_i.rd ? 2'b10 : 2'b01, cmd_i.phy, cmd_i.sel,
                           cmd_i.word[15:0]);
        rdf_q  <= cmd_i.rd;
        more_q <= 1'b0;
      end
    end else if (active_q) begin
      if (rise_i && rdf_q && bit_q >= BIT_W'(DAT_POS))
        rd_q <= {rd_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (last_bit) begin
          bit_q <= '0;
          if (more_q) begin
            sh_q   <= mk_frame(2'b00, cmd_q.rd ? 2'b11 : 2'b01, cmd_q.phy, cmd_q.sel,
                               cmd_q.word[15:0]);
            rdf_q  <= cmd_q.rd;
            more_q <= 1'b0;
          end else begin
            active_q <= 1'b0;
            rdf_q    <= 1'b0;
          end
        end else begin
          sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  // R7
  mdio_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && mdc_i && $past(mdc_i)) |-> $stable(mdio_o));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_valid_i,
  input  logic        reg_write_i,
  input  logic        reg_sel_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  localparam int BUSY_B = 0;
  localparam int C45_B  = 1;
  localparam int OPLO_B = 2;
  localparam int OPHI_B = 3;
  localparam int CK_LSB = 8;
  localparam int SEL_LSB = 16;
  localparam int PHY_LSB = SEL_LSB + FLD_W;

  logic [31:0]       cmd_q, data_q;
  logic              busy, cmd_wr, data_wr, launch;
  logic              eng_active, eng_done, rise, fall;
  logic [DATA_W-1:0] rd_data;
  mdio_cmd_t         eng_cmd;

  assign busy    = cmd_q[BUSY_B];
  assign cmd_wr  = reg_valid_i && reg_write_i && !reg_sel_i && !busy;
  assign data_wr = reg_valid_i && reg_write_i && reg_sel_i && !busy;
  assign launch  = cmd_wr && reg_wdata_i[BUSY_B] && reg_wdata_i[OPLO_B];
  assign reg_rdata_o = reg_sel_i ? data_q : cmd_q;

  assign eng_cmd.c45  = reg_wdata_i[C45_B];
  assign eng_cmd.rd   = reg_wdata_i[OPHI_B];
  assign eng_cmd.phy  = reg_wdata_i[PHY_LSB +: FLD_W];
  assign eng_cmd.sel  = reg_wdata_i[SEL_LSB +: FLD_W];
  assign eng_cmd.word = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (cmd_wr)
        cmd_q <= {reg_wdata_i[31:1], launch};
      else if (eng_done)
        cmd_q[BUSY_B] <= 1'b0;
      if (data_wr)
        data_q <= reg_wdata_i;
      else if (eng_done && cmd_q[OPHI_B])
        data_q[DATA_W-1:0] <= rd_data;
    end
  end

  mdio_mdc_gen u_mdc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (eng_active),
    .sel_i  (cmd_q[CK_LSB +: CKSEL_W]),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_eng u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (launch),
    .cmd_i     (eng_cmd),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdc_i     (mdc_o),
    .mdio_i    (mdio_i),
    .active_o  (eng_active),
    .done_o    (eng_done),
    .rd_data_o (rd_data),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
  );

  // R2
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !eng_done) |=> busy);
  // R2
  cmd_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && reg_valid_i && reg_write_i && !reg_sel_i) |=> $stable(cmd_q[31:1]));
  // R9
  data_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && reg_valid_i && reg_write_i && reg_sel_i && !eng_done) |=> $stable(data_q));
  // R6
  mdc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc_o);
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0, reg_write = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int checks = 0, errors = 0;
  int cyc = 0;

  logic cap_v [0:255];
  logic cap_oe[0:255];
  int   cap_n = 0;
  int   rise_cyc[0:1];
  logic [15:0] phy_val = '0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdio_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_valid_i(reg_valid), .reg_write_i(reg_write),
    .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mdc_o(mdc), .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  // PHY responder: records bits on MDC rise, answers read frames after decoding
  always @(posedge mdc) begin
    if (cap_n < 256) begin
      cap_v[cap_n]  = mdio_out;
      cap_oe[cap_n] = mdio_oe;
    end
    if (cap_n < 2) rise_cyc[cap_n] = cyc;
    cap_n = cap_n + 1;
  end

  always @(negedge mdc) begin
    int k, base;
    logic [1:0] st, op;
    k = cap_n % 64;
    base = cap_n - k;
    mdio_in = 1'b1;
    if (k >= 48 && base + 35 < 256) begin
      st = {cap_v[base+32], cap_v[base+33]};
      op = {cap_v[base+34], cap_v[base+35]};
      if ((st == 2'b01 && op == 2'b10) || (st == 2'b00 && op == 2'b11))
        mdio_in = phy_val[63-k];
    end
  end

  function automatic int period(input logic [2:0] c);
    case (c)
      3'd0: return 42; 3'd1: return 62; 3'd2: return 16;
      3'd3: return 26; 3'd4: return 102; 3'd5: return 124;
      default: return 42;
    endcase
  endfunction

  function automatic logic [63:0] exp_frame(input logic [1:0] st, input logic [1:0] op,
      input logic [4:0] p, input logic [4:0] s, input logic [15:0] d);
    logic [63:0] f;
    f[63:32] = 32'hFFFF_FFFF;
    f[31:30] = st; f[29:28] = op; f[27:23] = p; f[22:18] = s;
    f[17:16] = 2'b10; f[15:0] = d;
    return f;
  endfunction

  function automatic logic [31:0] mk_cmd(input logic busy, input logic c45,
      input logic [1:0] op, input logic [2:0] ck, input logic [4:0] s, input logic [4:0] p);
    logic [31:0] c = '0;
    c[0] = busy; c[1] = c45; c[3:2] = op; c[10:8] = ck; c[20:16] = s; c[25:21] = p;
    return c;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d, output int acc);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); #1 acc = cyc;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; #1 d = reg_rdata;
  endtask

  task automatic verify_frame(input int idx, input logic [63:0] f, input logic rdfr, input string req);
    int bad = 0;
    for (int i = 0; i < 64; i++) begin
      logic exp_oe;
      exp_oe = !(rdfr && i >= 46);
      if (cap_oe[idx*64+i] !== exp_oe) bad++;
      else if (exp_oe && cap_v[idx*64+i] !== f[63-i]) bad++;
    end
    check(req, bad, 0);
  endtask

  task automatic txn(input logic c45, input logic rdop, input logic [4:0] p, input logic [4:0] s,
                     input logic [2:0] ck, input logic [31:0] word, input logic [15:0] rv,
                     input logic poke_data);
    int acc, dn, nfr;
    logic [31:0] r;
    phy_val = rv;
    wr(1'b1, word, acc);
    cap_n = 0;
    wr(1'b0, mk_cmd(1'b1, c45, rdop ? 2'b11 : 2'b01, ck, s, p), acc);
    nfr = c45 ? 2 : 1;
    if (poke_data) begin
      wr(1'b1, 32'hDEAD_BEEF, dn);
      wr(1'b0, mk_cmd(1'b1, ~c45, 2'b01, ck + 3'd1, ~s, ~p), dn);
      rd(1'b0, r);
      check("R2 cmd write while busy", r, mk_cmd(1'b1, c45, rdop ? 2'b11 : 2'b01, ck, s, p));
    end
    dn = 0;
    for (int n = 0; n < 20000; n++) begin
      rd(1'b0, r);
      if (!r[0]) begin dn = cyc; break; end
    end
    check("R8 busy clear edge", dn - acc, nfr * 64 * period(ck));
    check("R6 MDC period", rise_cyc[1] - rise_cyc[0], period(ck));
    check("R3/R4 frame count", cap_n, nfr * 64);
    if (c45) begin
      verify_frame(0, exp_frame(2'b00, 2'b00, p, s, word[31:16]), 1'b0, "R4 address frame");
      verify_frame(1, exp_frame(2'b00, rdop ? 2'b11 : 2'b01, p, s, word[15:0]), rdop, "R4 access frame");
    end else begin
      verify_frame(0, exp_frame(2'b01, rdop ? 2'b10 : 2'b01, p, s, word[15:0]), rdop, "R3 c22 frame");
    end
    rd(1'b1, r);
    if (rdop) check("R5 read data", r, {word[31:16], rv});
    else      check("R9 data kept", r, word);
    check("R6 MDC idle low", mdc, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int acc, dn, n0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check("R1 mdc reset", mdc, 1'b0);
    check("R1 oe reset", mdio_oe, 1'b0);
    rd(1'b0, r); check("R1 cmd reset", r, 0);
    rd(1'b1, r); check("R1 data reset", r, 0);
    rst_n = 1'b1;
    @(negedge clk);

    txn(1'b0, 1'b0, 5'h13, 5'h0A, 3'd2, 32'h1234_A55A, 16'h0, 1'b0);
    txn(1'b0, 1'b1, 5'h01, 5'h1F, 3'd3, 32'hCAFE_0000, 16'hB00C, 1'b1);
    txn(1'b1, 1'b0, 5'h1E, 5'h07, 3'd0, 32'h8001_7FFE, 16'h0, 1'b0);
    txn(1'b1, 1'b1, 5'h05, 5'h03, 3'd7, 32'h00C3_1111, 16'h5A96, 1'b1);
    txn(1'b0, 1'b1, 5'h00, 5'h02, 3'd5, 32'h0, 16'hFFFF, 1'b0);
    txn(1'b0, 1'b0, 5'h1F, 5'h00, 3'd1, 32'h0000_0001, 16'h0, 1'b0);
    txn(1'b0, 1'b0, 5'h0C, 5'h11, 3'd4, 32'h0000_8000, 16'h0, 1'b0);
    for (int t = 0; t < 6; t++) begin
      logic [2:0] ck;
      case ($urandom % 3) 0: ck = 3'd2; 1: ck = 3'd3; default: ck = 3'd6; endcase
      txn(1'($urandom), 1'($urandom), 5'($urandom), 5'($urandom), ck, $urandom,
          16'($urandom), 1'($urandom));
    end

    // R10: no launch without busy bit or with a non-access opcode
    wr(1'b0, mk_cmd(1'b0, 1'b0, 2'b01, 3'd2, 5'h4, 5'h9), acc);
    rd(1'b0, r); check("R10 stored no busy", r, mk_cmd(1'b0, 1'b0, 2'b01, 3'd2, 5'h4, 5'h9));
    wr(1'b0, mk_cmd(1'b1, 1'b1, 2'b10, 3'd2, 5'h6, 5'h2), acc);
    rd(1'b0, r); check("R10 bad op no busy", r, mk_cmd(1'b0, 1'b1, 2'b10, 3'd2, 5'h6, 5'h2));
    n0 = cap_n;
    repeat (100) @(negedge clk);
    check("R10 no MDC activity", cap_n, n0);

    // R8: new command lands on the completion edge and is dropped
    wr(1'b1, 32'h0000_1357, acc);
    wr(1'b0, mk_cmd(1'b1, 1'b0, 2'b01, 3'd2, 5'h1, 5'h2), acc);
    while (cyc != acc + 64 * 16 - 1) @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_sel = 1'b0;
    reg_wdata = mk_cmd(1'b1, 1'b1, 2'b11, 3'd3, 5'h1C, 5'h1D);
    @(posedge clk); #1 dn = cyc;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
    check("R8 collide edge", dn - acc, 64 * 16);
    rd(1'b0, r); check("R8 collide dropped", r, mk_cmd(1'b0, 1'b0, 2'b01, 3'd2, 5'h1, 5'h2));
    n0 = cap_n;
    repeat (200) @(negedge clk);
    check("R8 no relaunch", cap_n, n0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule